// File: doc/BRIEF.md
# Debug halt request controller

This block decides when a processor core stops for debug. It watches four halt sources and either stops the core at once or records a pending stop that the core takes at its next per-instruction sample point. The four sources are a fault-on-fault indication, a hardware breakpoint trigger, a decoded halt instruction and an asynchronous active-low breakpoint pin. While the core is stopped, the block drives an all-ones status code to the status output. It holds the core stopped until a resume input releases it.

The halt instruction is privileged. In user mode it only halts the core when the user-halt enable bit from the configuration register is set. Otherwise the block raises a privilege-violation request for the exception logic. The breakpoint pin passes through a configurable synchronizer, and its falling edge arms a sticky pending bit, in the same way as an interrupt. When the core enters the halted state, a two-bit cause register records the highest-priority source that stopped it.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, `halted_o`, `halt_req_o` and `priv_viol_o` are 0, `cause_o` is 0, and `status_o` equals `core_status_i`.
- R2: A fault-on-fault input seen while the core is running raises `halt_req_o` in the same cycle, whether or not a sample strobe is present. `halted_o` is 1 from the next clock edge.
- R3: A hardware breakpoint pulse only arms a pending stop. `halt_req_o` stays 0 until a cycle with `sample_i` high, and in that cycle it is 1.
- R4: A halt instruction stops the core in the same cycle, with no sample strobe needed, when the core is in supervisor mode (`user_mode_i`=0) or when `user_halt_en_i`=1.
- R5: A halt instruction in user mode with `user_halt_en_i`=0 raises `priv_viol_o` in that cycle. It does not by itself raise `halt_req_o`.
- R6: A falling edge on `brk_pin_n_i`, after SYNC_STAGES flops, arms a sticky pending stop that is taken on the next `sample_i`. A pin held low does not arm it again.
- R7: While `halted_o`=1, `status_o` is 4'hF. Otherwise `status_o` equals `core_status_i`.
- R8: On entry to the halted state, `cause_o` records the highest-priority contributing source. The codes are: fault-on-fault=0, sampled hardware breakpoint=1, halt instruction=2, sampled pin=3.
- R9: Both pending bits are cleared on the edge that enters the halted state. After resume, a sample strobe with no new event does not stop the core.
- R10: `resume_i` while halted clears `halted_o` on the next edge. Sources that occur while halted are ignored and not latched.
- R11: `sample_i` with nothing pending and no immediate source leaves `halt_req_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fof_i | input | 1 | Fault-on-fault condition |
| hw_brk_i | input | 1 | Hardware breakpoint trigger pulse |
| halt_op_i | input | 1 | Halt instruction executing this cycle |
| user_mode_i | input | 1 | 1 when the core runs in user mode |
| user_halt_en_i | input | 1 | Configuration bit allowing the halt instruction in user mode |
| brk_pin_n_i | input | 1 | Asynchronous active-low breakpoint pin |
| sample_i | input | 1 | Per-instruction halt/interrupt sample strobe |
| resume_i | input | 1 | Release the halted state |
| core_status_i | input | STATUS_W | Status code from the core |
| halt_req_o | output | 1 | Stop the core now (entry cycle) |
| priv_viol_o | output | 1 | Privilege-violation exception request |
| halted_o | output | 1 | Core is in the halted state |
| status_o | output | STATUS_W | Processor status code |
| cause_o | output | 2 | Source of the latest halt entry |

## Verification
The hardest case to reach is a cycle in which several sources arrive together while a pin edge is still inside the synchronizer. In that case the cause must come from the priority, and the pending bits must be cleared even though a new event arrives on the entry edge. Directed sequences pre-arm the pending bits before a combined strobe cycle, and they pulse sources while halted and then resume. A seeded random phase then toggles the pin at random and mixes all sources, checked against a cycle model of the requirements.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
   typedef enum logic [1:0] {
      CAUSE_FOF    = 2'd0,
      CAUSE_HWBRK  = 2'd1,
      CAUSE_HALTOP = 2'd2,
      CAUSE_PIN    = 2'd3
   } halt_cause_e;
endpackage

// File: rtl/dbg_pin_edge.sv
module dbg_pin_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   output logic fall_o
);
   localparam int CHAIN_W = SYNC_STAGES + 1;

   logic [CHAIN_W-1:0] chain_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("dbg_pin_edge: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < CHAIN_W; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[s] <= 1'b1;
               else        chain_q[s] <= pin_n_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[s] <= 1'b1;
               else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   // Synchronized level is chain_q[SYNC_STAGES-1]; the extra flop holds its prior value.
   assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[SYNC_STAGES-1];

   AST_FALL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o); // R6
endmodule

// File: rtl/dbg_pend_bit.sv
module dbg_pend_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     pend_o <= 1'b0;
      else if (clr_i) pend_o <= 1'b0;
      else if (set_i) pend_o <= 1'b1;

   AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !pend_o); // R9
   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o && !clr_i |=> pend_o); // R6
endmodule

// File: rtl/dbg_halt_arb.sv
module dbg_halt_arb
   import dbg_halt_pkg::*;
(
   input  logic        running_i,
   input  logic        fof_i,
   input  logic        halt_op_ok_i,
   input  logic        hw_ready_i,
   input  logic        pin_ready_i,
   output logic        enter_o,
   output halt_cause_e cause_o
);
   always_comb begin
      enter_o = 1'b0;
      cause_o = CAUSE_FOF;
      if (running_i) begin
         if (fof_i) begin
            enter_o = 1'b1;
            cause_o = CAUSE_FOF;
         end else if (hw_ready_i) begin
            enter_o = 1'b1;
            cause_o = CAUSE_HWBRK;
         end else if (halt_op_ok_i) begin
            enter_o = 1'b1;
            cause_o = CAUSE_HALTOP;
         end else if (pin_ready_i) begin
            enter_o = 1'b1;
            cause_o = CAUSE_PIN;
         end
      end
   end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
   import dbg_halt_pkg::*;
#(
   parameter int STATUS_W    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fof_i,
   input  logic                hw_brk_i,
   input  logic                halt_op_i,
   input  logic                user_mode_i,
   input  logic                user_halt_en_i,
   input  logic                brk_pin_n_i,
   input  logic                sample_i,
   input  logic                resume_i,
   input  logic [STATUS_W-1:0] core_status_i,
   output logic                halt_req_o,
   output logic                priv_viol_o,
   output logic                halted_o,
   output logic [STATUS_W-1:0] status_o,
   output logic [1:0]          cause_o
);
   localparam logic [STATUS_W-1:0] HALT_CODE = {STATUS_W{1'b1}};

   generate
      if (STATUS_W < 2) begin : g_bad_status
         $error("dbg_halt_ctrl: STATUS_W must be at least 2");
      end
   endgenerate

   logic        halted_q;
   logic        pin_fall;
   logic        pend_hw, pend_pin;
   logic        halt_op_ok;
   logic        enter;
   halt_cause_e cause_d;
   logic [1:0]  cause_q;

   dbg_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n_i (brk_pin_n_i),
      .fall_o  (pin_fall)
   );

   // Events arriving while halted are dropped (set gated by running state).
   dbg_pend_bit u_pend_hw (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hw_brk_i & ~halted_q),
      .clr_i  (enter),
      .pend_o (pend_hw)
   );

   dbg_pend_bit u_pend_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (pin_fall & ~halted_q),
      .clr_i  (enter),
      .pend_o (pend_pin)
   );

   assign halt_op_ok = halt_op_i & (~user_mode_i | user_halt_en_i);

   dbg_halt_arb u_arb (
      .running_i    (~halted_q),
      .fof_i        (fof_i),
      .halt_op_ok_i (halt_op_ok),
      .hw_ready_i   (sample_i & pend_hw),
      .pin_ready_i  (sample_i & pend_pin),
      .enter_o      (enter),
      .cause_o      (cause_d)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         halted_q <= 1'b0;
         cause_q  <= CAUSE_FOF;
      end else if (halted_q) begin
         if (resume_i) halted_q <= 1'b0;
      end else if (enter) begin
         halted_q <= 1'b1;
         cause_q  <= cause_d;
      end

   assign halt_req_o  = enter;
   assign priv_viol_o = ~halted_q & halt_op_i & user_mode_i & ~user_halt_en_i;
   assign halted_o    = halted_q;
   assign cause_o     = cause_q;
   assign status_o    = halted_q ? HALT_CODE : core_status_i;

   AST_RESET_IDLE: assert property (@(posedge clk)
      $rose(rst_n) |-> !halted_o); // R1
   AST_FOF_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      fof_i && !halted_o |-> halt_req_o); // R2
   AST_REQ_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req_o |=> halted_o); // R2
   AST_PENDING_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req_o && !fof_i && !halt_op_i |-> sample_i); // R3
   AST_USER_OP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      priv_viol_o |=> cause_o != CAUSE_HALTOP || !$rose(halted_o)); // R5
   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> status_o == HALT_CODE); // R7
   AST_FOF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fof_i && !halted_o |=> cause_o == CAUSE_FOF); // R8
   AST_RESUME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o && resume_i |=> !halted_o); // R10
   AST_NO_REQ_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> !halt_req_o && !priv_viol_o); // R10
endmodule

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;
   localparam int SW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fof, hw, hop, umode, uhe, pin_n, samp, res;
   logic [SW-1:0] cst;
   logic req, pv, hlt;
   logic [SW-1:0] st;
   logic [1:0] cause;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // cycle model state
   bit m_h, m_phw, m_ppin, m_p1, m_p2, m_p3;
   logic [1:0] m_cause;

   always #4 clk = ~clk;

   dbg_halt_ctrl #(.STATUS_W(SW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .fof_i(fof), .hw_brk_i(hw), .halt_op_i(hop),
      .user_mode_i(umode), .user_halt_en_i(uhe), .brk_pin_n_i(pin_n),
      .sample_i(samp), .resume_i(res), .core_status_i(cst),
      .halt_req_o(req), .priv_viol_o(pv), .halted_o(hlt),
      .status_o(st), .cause_o(cause)
   );

   function automatic bit f_enter();
      return !m_h && (fof || (hop && (!umode || uhe)) || (samp && (m_phw || m_ppin)));
   endfunction

   function automatic logic [1:0] f_cause();
      if (fof)                      return 2'd0;
      if (samp && m_phw)            return 2'd1;
      if (hop && (!umode || uhe))   return 2'd2;
      return 2'd3;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic quiet();
      fof = 0; hw = 0; hop = 0; samp = 0; res = 0;
   endtask

   // Called at a negedge with inputs already set: check, advance one edge.
   task automatic step(input string tag);
      bit en, fall;
      logic [1:0] nc;
      #3;
      en = f_enter();
      nc = f_cause();
      fall = m_p3 && !m_p2;
      chk(tag, "halt_req", int'(req), int'(en));
      chk(tag, "priv_viol", int'(pv), int'(!m_h && hop && umode && !uhe));
      chk(tag, "halted", int'(hlt), int'(m_h));
      chk({tag, "/R7"}, "status", int'(st), m_h ? 15 : int'(cst));
      chk({tag, "/R8"}, "cause", int'(cause), int'(m_cause));
      @(posedge clk);
      if (m_h) begin
         if (res) m_h = 0;
      end else if (en) begin
         m_h = 1; m_cause = nc; m_phw = 0; m_ppin = 0;
      end else begin
         if (hw) m_phw = 1;
         if (fall) m_ppin = 1;
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_n;
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int n);
      quiet();
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      quiet(); umode = 0; uhe = 0; pin_n = 1; cst = 4'h3;
      m_h = 0; m_phw = 0; m_ppin = 0; m_p1 = 1; m_p2 = 1; m_p3 = 1; m_cause = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      #1;
      chk("R1", "halted", int'(hlt), 0);
      chk("R1", "halt_req", int'(req), 0);
      chk("R1", "cause", int'(cause), 0);
      chk("R1", "status", int'(st), 3);
      @(negedge clk);
      rst_n = 1;
      idle("R1", 2);
      // R11 sample with nothing pending
      quiet(); samp = 1; step("R11"); step("R11");
      // R2 fault-on-fault, no strobe
      quiet(); cst = 4'h5; fof = 1; step("R2");
      idle("R2", 2);
      quiet(); res = 1; step("R10"); idle("R10", 1);
      // R3 hardware breakpoint waits for strobe
      quiet(); hw = 1; step("R3");
      idle("R3", 3);
      quiet(); samp = 1; step("R3");
      idle("R3", 1);
      quiet(); res = 1; step("R3");
      // R9 no re-halt after resume
      quiet(); samp = 1; step("R9"); step("R9");
      // R4 halt instruction, supervisor then user with enable
      quiet(); hop = 1; step("R4"); quiet(); res = 1; step("R4");
      quiet(); umode = 1; uhe = 1; hop = 1; step("R4"); quiet(); res = 1; step("R4");
      // R5 user mode without enable
      quiet(); uhe = 0; hop = 1; step("R5"); step("R5");
      quiet(); samp = 1; step("R5"); umode = 0;
      // R6 pin falling edge through synchronizer
      quiet(); pin_n = 0; idle("R6", 5);
      quiet(); samp = 1; step("R6"); quiet(); res = 1; step("R6");
      quiet(); samp = 1; step("R6"); step("R6");
      pin_n = 1; idle("R6", 4);
      // R8 simultaneous sources
      quiet(); hw = 1; step("R8");
      quiet(); fof = 1; hop = 1; samp = 1; step("R8");
      quiet(); res = 1; step("R8");
      quiet(); hw = 1; step("R8");
      quiet(); hop = 1; samp = 1; step("R8"); quiet(); res = 1; step("R8");
      quiet(); pin_n = 0; idle("R8", 5);
      quiet(); hop = 1; samp = 1; step("R8"); quiet(); res = 1; step("R8");
      quiet(); samp = 1; step("R9");
      pin_n = 1; idle("R8", 4);
      // R10 sources while halted are dropped
      quiet(); fof = 1; step("R10");
      quiet(); hw = 1; step("R10");
      quiet(); pin_n = 0; idle("R10", 4);
      quiet(); res = 1; step("R10");
      quiet(); samp = 1; step("R10"); step("R10");
      pin_n = 1; idle("R10", 4);
      // random mix against the cycle model
      for (int i = 0; i < 3000; i++) begin
         quiet();
         fof   = ($urandom_range(0, 39) == 0);
         hw    = ($urandom_range(0, 9) == 0);
         hop   = ($urandom_range(0, 14) == 0);
         umode = $urandom_range(0, 1);
         uhe   = ($urandom_range(0, 2) == 0);
         samp  = ($urandom_range(0, 3) == 0);
         res   = ($urandom_range(0, 3) == 0);
         cst   = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 11) == 0) pin_n = ~pin_n;
         step("R8");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule